// File: doc/BRIEF.md
# Prioritized Interrupt Request/Service Tracker

This block holds the pending-request, in-service and trigger-mode state for a single interrupt target. Each state is one bit per vector, 256 vectors in all, kept as eight 32-bit words. Vectors are grouped into classes of sixteen, and the class is bits 7:4 of the vector number. The block derives a processor priority from a programmable task priority and the highest vector now in service. It drives an interrupt line while the highest pending request is in a class above that priority.

Requests arrive on a set port that carries a vector number and a trigger mode. The processor side answers the interrupt line with an acknowledge pulse. The block replies one cycle later with a grant kind and a vector, and moves the granted request into service. An end-of-interrupt pulse retires the highest in-service vector. When that vector was level-triggered, the block emits a broadcast strobe carrying its number, unless directed end-of-interrupt is enabled. A task-priority register and a spurious-vector control register are written through simple write strobes.

The highest-set-bit search over each vector is a combinational encoder whose result is registered. Results of an operation are therefore visible on the interrupt line two clock edges after the operation is sampled.

Top module: `irqt_top`

## Requirements
- R1: A set pulse marks the vector pending and records its trigger mode, with 1 meaning level and 0 meaning edge. A later set of the same vector overwrites the recorded mode.
- R2: Among pending requests the highest-numbered vector has the highest priority, and vectors 0 and 255 are valid like any other.
- R3: Processor priority is the task-priority value when its bits 7:4 are at least the class of the highest in-service vector. Otherwise it is that in-service class placed in bits 7:4 with zeros below. An empty in-service set counts as class 0.
- R4: A pending request is deliverable only when its class is strictly above the processor-priority class. A processor priority of 0 makes any pending request deliverable.
- R5: `irq_out` is high exactly when the enable bit is set and the highest pending request is deliverable. It reflects an operation two clock edges after that operation is sampled.
- R6: The cycle after an acknowledge pulse, `ack_vld` is high for one cycle. On a grant, `ack_kind` is 1 and `ack_vec` is the highest pending vector, and that vector leaves the pending set and enters the in-service set.
- R7: When requests are pending and enabled but none is deliverable, an acknowledge returns `ack_kind` 2 with `ack_vec` equal to bits 7:0 of the spurious-vector register, and no pending or in-service state changes.
- R8: When nothing is pending, or the enable bit is clear, an acknowledge returns `ack_kind` 0 and `ack_vec` 0, with no state change.
- R9: An end-of-interrupt pulse clears the highest in-service vector. With nothing in service it has no effect.
- R10: When the retired vector is level-triggered and the directed end-of-interrupt bit (bit 12) is clear, `bcast_vld` pulses the cycle after the end-of-interrupt pulse, with that vector on `bcast_vec`. Otherwise no broadcast occurs.
- R11: A spurious-vector write keeps only bits 12 and 8:0. Bit 8 is the enable. The reset value is 0x0FF, which leaves the block disabled.
- R12: A task-priority write replaces the 8-bit task priority, whose reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_vld | input | 1 | Request set strobe |
| set_vec | input | 8 | Vector to set |
| set_level | input | 1 | Trigger mode of the set: 1 level, 0 edge |
| ack_req | input | 1 | Acknowledge pulse from the processor side |
| eoi_strobe | input | 1 | End-of-interrupt pulse |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| svr_we | input | 1 | Spurious-vector register write strobe |
| svr_wdata | input | 32 | Spurious-vector register write data |
| irq_out | output | 1 | Interrupt line |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_kind | output | 2 | 0 none, 1 granted, 2 spurious |
| ack_vec | output | 8 | Granted or spurious vector |
| bcast_vld | output | 1 | End-of-interrupt broadcast strobe |
| bcast_vec | output | 8 | Vector being broadcast |

## Verification
The bench places a request at the boundary of the in-service class, at 0x9F against 0x91. An off-by-one class compare would raise the interrupt there. It lowers the task priority while a higher class is in service, which exposes a design that uses the task priority alone. It retriggers one vector as level and then as edge, and as edge and then as level, to show that the last mode decides whether the end-of-interrupt is broadcast; a sticky mode bit would emit or lose a broadcast. It also acknowledges with requests that are pending but masked, so that a design that consumed the request, or returned the wrong spurious vector, shows up in the following grants. Vectors 0 and 255 are granted, to catch an encoder that treats vector 0 as empty.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_VEC  = 2'd1,
        ACK_SPUR = 2'd2
    } ack_kind_e;
endpackage

// File: rtl/irqt_msb_enc.sv
// Highest-set-bit finder: per-word encoders, then pick the topmost non-empty word.
module irqt_msb_enc #(
    parameter int N  = 256,
    parameter int WW = 32,
    localparam int IW = $clog2(N),
    localparam int NW = N / WW,
    localparam int LW = $clog2(WW)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [NW-1:0] w_any;
    logic [LW-1:0] w_loc [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [LW-1:0] loc;
        always_comb begin
            loc = '0;
            for (int b = 0; b < WW; b++) begin
                if (vec[g*WW + b]) loc = LW'(b);
            end
        end
        assign w_loc[g] = loc;
        assign w_any[g] = |vec[g*WW +: WW];
    end

    always_comb begin
        any = |w_any;
        idx = '0;
        for (int w = 0; w < NW; w++) begin
            if (w_any[w]) idx = IW'(w * WW) | IW'(w_loc[w]);
        end
    end
endmodule

// File: rtl/irqt_prio.sv
// Processor-priority derivation and deliverability compare.
module irqt_prio #(
    parameter int VW        = 8,
    parameter int CLS_SHIFT = 4,
    localparam int CW = VW - CLS_SHIFT
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    input  logic          irr_any,
    input  logic [VW-1:0] irr_top,
    output logic [VW-1:0] ppr,
    output logic          deliver
);
    logic [CW-1:0] isr_cls_d;
    logic [CW-1:0] tpr_cls_d;
    logic [CW-1:0] irr_cls_d;

    always_comb begin
        isr_cls_d = isr_any ? isr_top[VW-1:CLS_SHIFT] : '0;
        tpr_cls_d = tpr[VW-1:CLS_SHIFT];
        irr_cls_d = irr_top[VW-1:CLS_SHIFT];
        ppr       = (tpr_cls_d >= isr_cls_d) ? tpr : {isr_cls_d, {CLS_SHIFT{1'b0}}};
        deliver   = irr_any && ((ppr == '0) || (irr_cls_d > ppr[VW-1:CLS_SHIFT]));
    end
endmodule

// File: rtl/irqt_top.sv
module irqt_top
    import irqt_pkg::*;
#(
    parameter int          NUM_VEC   = 256,
    parameter int          WORD_W    = 32,
    parameter int          CLS_SHIFT = 4,
    parameter int          EN_BIT    = 8,
    parameter int          DEOI_BIT  = 12,
    parameter logic [31:0] SVR_RST   = 32'h0000_00FF,
    localparam int         VW        = $clog2(NUM_VEC),
    localparam logic [31:0] SVR_MASK = ((32'd1 << (EN_BIT + 1)) - 32'd1) | (32'd1 << DEOI_BIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_vld,
    input  logic [VW-1:0] set_vec,
    input  logic          set_level,
    input  logic          ack_req,
    input  logic          eoi_strobe,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    input  logic          svr_we,
    input  logic [31:0]   svr_wdata,
    output logic          irq_out,
    output logic          ack_vld,
    output logic [1:0]    ack_kind,
    output logic [VW-1:0] ack_vec,
    output logic          bcast_vld,
    output logic [VW-1:0] bcast_vec
);
    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VW-1:0]      tpr;
        logic [31:0]        svr;
        logic               hi_irr_v;
        logic [VW-1:0]      hi_irr;
        logic               hi_isr_v;
        logic [VW-1:0]      hi_isr;
        logic               ack_v;
        ack_kind_e          ack_k;
        logic [VW-1:0]      ack_vec;
        logic               bc_v;
        logic [VW-1:0]      bc_vec;
    } st_t;

    st_t st_d, st_q;

    logic          enc_irr_any, enc_isr_any;
    logic [VW-1:0] enc_irr_idx, enc_isr_idx;
    logic [VW-1:0] ppr_w;
    logic          deliver_w;
    logic          enabled_w;

    irqt_msb_enc #(.N(NUM_VEC), .WW(WORD_W)) u_enc_irr (
        .vec(st_q.irr), .any(enc_irr_any), .idx(enc_irr_idx)
    );

    irqt_msb_enc #(.N(NUM_VEC), .WW(WORD_W)) u_enc_isr (
        .vec(st_q.isr), .any(enc_isr_any), .idx(enc_isr_idx)
    );

    irqt_prio #(.VW(VW), .CLS_SHIFT(CLS_SHIFT)) u_prio (
        .tpr     (st_q.tpr),
        .isr_any (st_q.hi_isr_v),
        .isr_top (st_q.hi_isr),
        .irr_any (st_q.hi_irr_v),
        .irr_top (st_q.hi_irr),
        .ppr     (ppr_w),
        .deliver (deliver_w)
    );

    assign enabled_w = st_q.svr[EN_BIT];

    always_comb begin
        st_d          = st_q;
        st_d.hi_irr_v = enc_irr_any;
        st_d.hi_irr   = enc_irr_idx;
        st_d.hi_isr_v = enc_isr_any;
        st_d.hi_isr   = enc_isr_idx;
        st_d.ack_v    = 1'b0;
        st_d.ack_k    = ACK_NONE;
        st_d.ack_vec  = '0;
        st_d.bc_v     = 1'b0;
        st_d.bc_vec   = '0;

        if (ack_req) begin
            st_d.ack_v = 1'b1;
            if (enabled_w && st_q.hi_irr_v) begin
                if (deliver_w) begin
                    st_d.ack_k              = ACK_VEC;
                    st_d.ack_vec            = st_q.hi_irr;
                    st_d.irr[st_q.hi_irr]   = 1'b0;
                    st_d.isr[st_q.hi_irr]   = 1'b1;
                end else begin
                    st_d.ack_k   = ACK_SPUR;
                    st_d.ack_vec = st_q.svr[VW-1:0];
                end
            end
        end

        if (eoi_strobe && st_q.hi_isr_v) begin
            st_d.isr[st_q.hi_isr] = 1'b0;
            if (st_q.tmr[st_q.hi_isr] && !st_q.svr[DEOI_BIT]) begin
                st_d.bc_v   = 1'b1;
                st_d.bc_vec = st_q.hi_isr;
            end
        end

        if (set_vld) begin
            st_d.irr[set_vec] = 1'b1;
            st_d.tmr[set_vec] = set_level;
        end

        if (tpr_we) st_d.tpr = tpr_wdata;
        if (svr_we) st_d.svr = svr_wdata & SVR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.svr <= SVR_RST & SVR_MASK;
        end else begin
            st_q     <= st_d;
        end
    end

    assign irq_out   = enabled_w && deliver_w;
    assign ack_vld   = st_q.ack_v;
    assign ack_kind  = st_q.ack_k;
    assign ack_vec   = st_q.ack_vec;
    assign bcast_vld = st_q.bc_v;
    assign bcast_vec = st_q.bc_vec;

    // R6
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_vld);

    // R1
    tmr_follows_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> (st_q.tmr[$past(set_vec)] == $past(set_level)));

    // R10
    bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_vld |-> ($past(eoi_strobe) && !$past(st_q.svr[DEOI_BIT])));

    // R7
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_kind == ACK_SPUR) |-> (ack_vec == $past(st_q.svr[VW-1:0])));

    // R5
    grant_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_kind == ACK_VEC) |-> $past(irq_out));
endmodule

// File: tb/sim_irqt_top.sv
module sim_irqt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_vld = 1'b0;
    logic [7:0]  set_vec = '0;
    logic        set_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        eoi_strobe = 1'b0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [31:0] svr_wdata = '0;
    logic        irq_out, ack_vld, bcast_vld;
    logic [1:0]  ack_kind;
    logic [7:0]  ack_vec, bcast_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] k;
        logic [7:0] v;
        string      r;
    } exp_t;

    exp_t ack_q[$];
    exp_t bc_q[$];
    exp_t cur_e;

    always #10 clk = ~clk;

    irqt_top u0 (
        .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_vec(set_vec),
        .set_level(set_level), .ack_req(ack_req), .eoi_strobe(eoi_strobe),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .svr_we(svr_we),
        .svr_wdata(svr_wdata), .irq_out(irq_out), .ack_vld(ack_vld),
        .ack_kind(ack_kind), .ack_vec(ack_vec), .bcast_vld(bcast_vld),
        .bcast_vec(bcast_vec)
    );

    // Monitor: pop expected results as the design presents them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack_vld) begin
                checks++;
                if (ack_q.size() == 0) begin
                    failures++;
                    $display("FAIL R6 unexpected ack: kind=%0d vec=%02h expected none", ack_kind, ack_vec);
                end else begin
                    cur_e = ack_q.pop_front();
                    if (ack_kind !== cur_e.k || ack_vec !== cur_e.v) begin
                        failures++;
                        $display("FAIL %s ack: kind=%0d vec=%02h expected kind=%0d vec=%02h",
                                 cur_e.r, ack_kind, ack_vec, cur_e.k, cur_e.v);
                    end
                end
            end
            if (bcast_vld) begin
                checks++;
                if (bc_q.size() == 0) begin
                    failures++;
                    $display("FAIL R10 unexpected broadcast: vec=%02h expected none", bcast_vec);
                end else begin
                    cur_e = bc_q.pop_front();
                    if (bcast_vec !== cur_e.v) begin
                        failures++;
                        $display("FAIL %s broadcast: vec=%02h expected %02h", cur_e.r, bcast_vec, cur_e.v);
                    end
                end
            end
        end
    end

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_set(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        set_vld = 1'b1; set_vec = v; set_level = lvl;
        @(negedge clk);
        set_vld = 1'b0;
        settle();
    endtask

    task automatic do_ack(input logic [1:0] k, input logic [7:0] v, input string r);
        exp_t e;
        e.k = k; e.v = v; e.r = r;
        ack_q.push_back(e);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        settle();
    endtask

    task automatic do_eoi(input bit bc, input logic [7:0] v, input string r);
        exp_t e;
        e.k = 2'd0; e.v = v; e.r = r;
        if (bc) bc_q.push_back(e);
        @(negedge clk);
        eoi_strobe = 1'b1;
        @(negedge clk);
        eoi_strobe = 1'b0;
        settle();
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        @(negedge clk);
        tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk);
        tpr_we = 1'b0;
        settle();
    endtask

    task automatic wr_svr(input logic [31:0] v);
        @(negedge clk);
        svr_we = 1'b1; svr_wdata = v;
        @(negedge clk);
        svr_we = 1'b0;
        settle();
    endtask

    task automatic chk_irq(input logic exp, input string r);
        checks++;
        if (irq_out !== exp) begin
            failures++;
            $display("FAIL %s irq_out=%0b expected %0b", r, irq_out, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 R12 reset state: disabled, nothing pending, no strobes
        checks++;
        if (irq_out !== 1'b0 || ack_vld !== 1'b0 || bcast_vld !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset outputs irq=%0b ack=%0b bc=%0b expected 0 0 0", irq_out, ack_vld, bcast_vld);
        end

        // R5 R8: disabled at reset, pending request ignored
        do_set(8'h45, 1'b0);
        chk_irq(1'b0, "R5");
        do_ack(2'd0, 8'h00, "R8");
        chk_irq(1'b0, "R5");

        // R11: upper bits dropped, enable kept
        wr_svr(32'hFFFF_EFA7);
        chk_irq(1'b1, "R11");

        // R2 R6 R3
        do_set(8'h91, 1'b1);
        do_ack(2'd1, 8'h91, "R2");
        chk_irq(1'b0, "R3");

        // R7: spurious, twice, no state change
        do_ack(2'd2, 8'hA7, "R7");
        do_ack(2'd2, 8'hA7, "R7");
        chk_irq(1'b0, "R7");

        // R4 strict class compare
        do_set(8'h9F, 1'b0);
        chk_irq(1'b0, "R4");
        do_set(8'hA0, 1'b0);
        chk_irq(1'b1, "R4");
        do_ack(2'd1, 8'hA0, "R6");
        chk_irq(1'b0, "R3");

        // R9 R10: edge vector no broadcast, level vector broadcast
        do_eoi(1'b0, 8'h00, "R10");
        chk_irq(1'b0, "R9");
        do_eoi(1'b1, 8'h91, "R10");
        chk_irq(1'b1, "R9");

        // R12 R3 task priority
        wr_tpr(8'h95);
        chk_irq(1'b0, "R12");
        wr_tpr(8'h80);
        chk_irq(1'b1, "R12");
        do_ack(2'd1, 8'h9F, "R2");
        chk_irq(1'b0, "R3");
        wr_tpr(8'hA0);
        chk_irq(1'b0, "R3");
        wr_tpr(8'h30);
        chk_irq(1'b0, "R3");
        wr_tpr(8'h00);
        chk_irq(1'b0, "R3");
        do_eoi(1'b0, 8'h00, "R10");
        chk_irq(1'b1, "R9");

        // R10 directed end-of-interrupt suppresses broadcast
        wr_svr(32'h0000_11A7);
        do_set(8'h66, 1'b1);
        do_ack(2'd1, 8'h66, "R2");
        do_eoi(1'b0, 8'h00, "R10");

        // R1 retrigger: last mode wins
        do_set(8'h70, 1'b1);
        do_set(8'h70, 1'b0);
        wr_svr(32'h0000_01A7);
        do_ack(2'd1, 8'h70, "R1");
        do_eoi(1'b0, 8'h00, "R1");
        do_set(8'h71, 1'b0);
        do_set(8'h71, 1'b1);
        do_ack(2'd1, 8'h71, "R1");
        do_eoi(1'b1, 8'h71, "R1");

        // R9 empty in-service: no effect
        do_eoi(1'b0, 8'h00, "R9");
        chk_irq(1'b1, "R9");

        // R2 boundary vectors 255 and 0
        do_set(8'hFF, 1'b1);
        do_ack(2'd1, 8'hFF, "R2");
        do_eoi(1'b1, 8'hFF, "R10");
        do_ack(2'd1, 8'h45, "R2");
        do_eoi(1'b0, 8'h00, "R9");
        chk_irq(1'b0, "R5");
        do_ack(2'd0, 8'h00, "R8");
        do_set(8'h00, 1'b0);
        chk_irq(1'b1, "R4");
        do_ack(2'd1, 8'h00, "R2");
        do_eoi(1'b0, 8'h00, "R9");
        chk_irq(1'b0, "R5");

        // R11 disable holds line low
        do_set(8'h45, 1'b0);
        chk_irq(1'b1, "R5");
        wr_svr(32'h0000_00A7);
        chk_irq(1'b0, "R11");
        do_ack(2'd0, 8'h00, "R8");

        repeat (3) @(negedge clk);
        checks++;
        if (ack_q.size() != 0 || bc_q.size() != 0) begin
            failures++;
            $display("FAIL R10 missing results: acks=%0d broadcasts=%0d expected 0 0", ack_q.size(), bc_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired: run incomplete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule